// File: doc/BRIEF.md
# Dual-Path Synthesizer Configuration Register

This block keeps the 14-bit setting word of a frequency synthesizer. The word has three fields: a 9-bit loop-divider value, a 2-bit output-divider code and a 3-bit test-select code. Two independent routes can write it. The serial route is a three-wire port with a data line, a shift clock and a load strobe. Bits are shifted into a 14-stage register, and while the strobe is high that register is copied through to the outputs. The parallel route has divider pins and a load strobe. While that strobe is low the outputs track the pins, and its rising edge freezes them.

All inputs are sampled by the system clock. The strobes act as level-sensitive latch enables that are evaluated every clock. The serial shift clock is edge-detected, so each low-to-high transition causes exactly one shift. The parallel route takes priority over the serial route for the divider fields. The test-select field can only be written over the serial route.

Top module: `cfg_dualload`

## Requirements
- R1: While `rst` is high at a clock edge, `t_out` becomes 000, `m_out` takes the value of `par_m` and `n_out` takes the value of `par_n`.
- R2: Each low-to-high transition of `ser_clk` shifts the register once, with `ser_dat` entering bit 0. Holding `ser_clk` high for many cycles gives only one shift. After 14 shifts the first bit sent sits in bit 13. The word layout is test-select in bits 13..11, output divider in bits 10..9 and loop divider in bits 8..0.
- R3: While `ser_ld` is high and `par_ld` is high, `m_out`, `n_out` and `t_out` follow the shift register's fields, including partial words as bits arrive.
- R4: While `ser_ld` is low, shifting new bits leaves `m_out`, `n_out` and `t_out` unchanged. The outputs keep the value the register held when `ser_ld` fell.
- R5: While `par_ld` is low, `m_out` and `n_out` follow `par_m` and `par_n`. `par_m[8]` is the most significant bit of the loop-divider value.
- R6: After `par_ld` rises, later changes on `par_m` and `par_n` have no effect on the outputs.
- R7: While `par_ld` is low, a serial load has no effect on `m_out` or `n_out`, but it still updates `t_out`.
- R8: Parallel activity never changes `t_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock; acts on its rising transition |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial latch enable, transparent while high |
| par_ld | input | 1 | Parallel latch enable, transparent while low |
| par_m | input | 9 | Parallel loop-divider value |
| par_n | input | 2 | Parallel output-divider code |
| m_out | output | 9 | Current loop-divider value |
| n_out | output | 2 | Current output-divider code |
| t_out | output | 3 | Current test-select code |

## Verification
The hardest case to reach is a serial load that arrives while the parallel latch is still transparent. The divider fields must ignore it while the test field accepts it. The bench holds `par_ld` low, shifts a complete word whose divider fields differ from the pins, and pulses `ser_ld`. Partial-word transparency is a second corner. For it, the bench keeps `ser_ld` high during shifting and compares the outputs against its own shift model after a single extra bit. A long high phase on the shift clock confirms that a level held high produces only one shift.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
    localparam int M_W    = 9;
    localparam int N_W    = 2;
    localparam int T_W    = 3;
    localparam int WORD_W = T_W + N_W + M_W;

    // First bit shifted in ends up at the top: test field, then N, then M.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    function automatic cfg_word_t as_word(input logic [WORD_W-1:0] v);
        return cfg_word_t'(v);
    endfunction

    function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] v,
                                                   input logic b);
        return {v[WORD_W-2:0], b};
    endfunction
endpackage

// File: rtl/cfg_edge.sv
module cfg_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk) begin
        prev <= lvl;   // seeded from the live level in reset: no false edge
    end

    assign rise = lvl & ~prev & ~rst;

    p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              din,
    output logic [WORD_W-1:0] sreg
);
    always_ff @(posedge clk) begin
        if (rst)
            sreg <= '0;
        else if (step)
            sreg <= shift_in(sreg, din);
    end

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(sreg));
    p_bit_entry_r2: assert property (@(posedge clk) disable iff (rst)
        step |=> sreg[0] == $past(din));
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
    import cfgreg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           par_ld,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_ld,
    input  cfg_word_t      ser_word,
    output cfg_word_t      cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.t <= '0;
            cfg.m <= par_m;
            cfg.n <= par_n;
        end else begin
            // parallel transparency wins for the divider fields
            if (!par_ld) begin
                cfg.m <= par_m;
                cfg.n <= par_n;
            end else if (ser_ld) begin
                cfg.m <= ser_word.m;
                cfg.n <= ser_word.n;
            end
            if (ser_ld)
                cfg.t <= ser_word.t;
        end
    end

    p_dividers_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (par_ld && !ser_ld) |=> $stable(cfg.m) && $stable(cfg.n));
    p_test_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !ser_ld |=> $stable(cfg.t));
endmodule

// File: rtl/cfg_dualload.sv
module cfg_dualload
    import cfgreg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_dat,
    input  logic           ser_ld,
    input  logic           par_ld,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic [T_W-1:0] t_out
);
    logic              shift_step;
    logic [WORD_W-1:0] sreg;
    cfg_word_t         cfg;

    cfg_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ser_clk),
        .rise (shift_step)
    );

    cfg_shift u_shift (
        .clk  (clk),
        .rst  (rst),
        .step (shift_step),
        .din  (ser_dat),
        .sreg (sreg)
    );

    cfg_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .par_ld   (par_ld),
        .par_m    (par_m),
        .par_n    (par_n),
        .ser_ld   (ser_ld),
        .ser_word (as_word(sreg)),
        .cfg      (cfg)
    );

    assign m_out = cfg.m;
    assign n_out = cfg.n;
    assign t_out = cfg.t;

    p_par_follow_r5: assert property (@(posedge clk) disable iff (rst)
        !par_ld |=> (m_out == $past(par_m)) && (n_out == $past(par_n)));
    p_par_priority_r7: assert property (@(posedge clk) disable iff (rst)
        (!par_ld && ser_ld) |=> m_out == $past(par_m));
endmodule

// File: tb/sim_cfg_dualload.sv
module sim_cfg_dualload;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, par_ld = 1'b0;
    logic [8:0] par_m = 9'd262;
    logic [1:0] par_n = 2'd1;
    logic [8:0] m_out;
    logic [1:0] n_out;
    logic [2:0] t_out;
    logic [13:0] model_sr = '0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cfg_dualload u0 (.clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
                     .ser_ld(ser_ld), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
                     .m_out(m_out), .n_out(n_out), .t_out(t_out));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input int m, input int n, input int t);
        chk(req, m_out, m);
        chk(req, n_out, n);
        chk(req, t_out, t);
    endtask

    task automatic send_bit(input logic b, input int hi);
        ser_dat = b;
        tick(1);
        ser_clk = 1'b1;
        tick(hi);
        ser_clk = 1'b0;
        tick(2);
        model_sr = {model_sr[12:0], b};
    endtask

    task automatic send_word(input logic [2:0] t, input logic [1:0] n,
                             input logic [8:0] m, input int hi);
        logic [13:0] w = {t, n, m};
        for (int i = 13; i >= 0; i--) send_bit(w[i], hi);
    endtask

    task automatic strobe_ser();
        ser_ld = 1'b1;
        tick(2);
        ser_ld = 1'b0;
        tick(2);
    endtask

    task automatic t_reset();
        tick(3);
        rst = 1'b0;
        tick(1);
        chk_all("R1", 262, 1, 0);
        par_ld = 1'b1;
        tick(2);
    endtask

    task automatic t_parallel();
        par_ld = 1'b0; par_m = 9'b100101100; par_n = 2'd2;
        tick(2);
        chk_all("R5", 300, 2, 0);
        par_ld = 1'b1;
        tick(1);
        par_m = 9'd111; par_n = 2'd3;
        tick(3);
        chk_all("R6", 300, 2, 0);   // T untouched too: R8
        chk("R8", t_out, 0);
    endtask

    task automatic t_serial();
        send_word(3'd5, 2'd3, 9'h1A5, 1);
        strobe_ser();
        chk_all("R2", 9'h1A5, 3, 5);
        // long high phases: still one shift per transition (R2)
        send_word(3'd6, 2'd0, 9'd77, 9);
        strobe_ser();
        chk_all("R2", 77, 0, 6);
        // shifting with the strobe low leaves outputs alone (R4)
        send_word(3'd1, 2'd1, 9'd400, 1);
        chk_all("R4", 77, 0, 6);
    endtask

    task automatic t_transparent();
        ser_ld = 1'b1;
        tick(2);
        chk_all("R3", model_sr[8:0], model_sr[10:9], model_sr[13:11]);
        send_bit(1'b1, 1);
        chk_all("R3", model_sr[8:0], model_sr[10:9], model_sr[13:11]);
        ser_ld = 1'b0;
        tick(2);
        begin
            logic [13:0] held = model_sr;
            send_bit(1'b0, 1);
            send_bit(1'b1, 1);
            chk_all("R4", held[8:0], held[10:9], held[13:11]);
        end
    endtask

    task automatic t_priority();
        par_ld = 1'b0; par_m = 9'd200; par_n = 2'd0;
        send_word(3'd2, 2'd1, 9'd399, 1);
        strobe_ser();
        chk_all("R7", 200, 0, 2);
        par_ld = 1'b1;
        tick(2);
        par_m = 9'd5;
        tick(2);
        chk_all("R6", 200, 0, 2);
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_serial();
        t_transparent();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule